// File: doc/BRIEF.md
# Interrupt Accept and In-Service Retirement Unit

This block keeps the interrupt state on the processor side of an interrupt fabric. There are 256 vectors. For each one the block holds a pending-request bit, an in-service bit and a trigger-mode bit. A request port files an incoming vector as pending and records whether the source is level-sensitive. A dispatch strobe moves a chosen vector from pending to in-service. An end-of-interrupt strobe retires the highest-numbered in-service vector in one cycle.

Vectors 0 to 31 (word 0) are never searched by a retirement. When the retired vector was recorded as level-sensitive, the block raises an outgoing end-of-interrupt notice that carries the vector, so an upstream router can re-evaluate the shared line. The notice stays on its output until the router acknowledges it. Interrupts that the processor generates for itself, such as its own timer and fixed-mode inter-processor messages, are flagged as local on the request port and are always recorded as edge-sensitive.

Top module: `intr_accept_eoi`

## Requirements
- R1: After reset, all pending, in-service and trigger-mode bits are 0, the in-service depth is 0, no notice is pending and the error flag is 0.
- R2: A request with `acceptValid` high sets bit `acceptVector` of `irrVec`. That bit lives in 32-bit word `acceptVector[7:5]` at position `acceptVector[4:0]`. The same request sets bit `acceptVector` of `tmrVec` when `acceptLevel` is 1 and clears it when `acceptLevel` is 0.
- R3: A request with `acceptLocal` high always clears its `tmrVec` bit, whatever the value of `acceptLevel`.
- R4: A dispatch clears bit `serviceVector` of `irrVec` and sets it in `isrVec`. The depth rises by one unless that in-service bit was already set and is not being retired in the same cycle. A request for the same vector in the same cycle leaves the pending bit set.
- R5: An end-of-interrupt that is accepted clears only the highest set `isrVec` bit among vectors 32 to 255 and lowers the depth by one.
- R6: In-service vectors 0 to 31 are never retired. With only such vectors in service, an end-of-interrupt changes nothing and raises no error.
- R7: A retired vector whose `tmrVec` bit was set before that cycle raises `eoiMsgValid` on the next cycle, with `eoiMsgVector` equal to the vector. An edge-sensitive retirement raises no notice.
- R8: While `eoiMsgValid` is high and `eoiMsgAck` is low, the notice and its vector hold steady. An acknowledge drops the notice on the next cycle unless a new notice is loaded in the same cycle.
- R9: An end-of-interrupt while the depth is 0 sets `eoiError` and changes no other state. `eoiError` stays set until reset.
- R10: An end-of-interrupt while a notice is pending and not acknowledged in that cycle is refused. It sets `eoiError` and leaves the in-service bits and the depth unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acceptValid | input | 1 | File a new request |
| acceptVector | input | 8 | Vector of the request |
| acceptLevel | input | 1 | 1 when the source is level-sensitive |
| acceptLocal | input | 1 | 1 for locally generated interrupts (forced edge) |
| serviceValid | input | 1 | Dispatch a vector into service |
| serviceVector | input | 8 | Vector being dispatched |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiMsgValid | output | 1 | Outgoing end-of-interrupt notice pending |
| eoiMsgVector | output | 8 | Vector carried by the notice |
| eoiMsgAck | input | 1 | Router acknowledge of the notice |
| irrVec | output | 256 | Pending-request bits |
| isrVec | output | 256 | In-service bits |
| tmrVec | output | 256 | Trigger-mode bits (1 = level) |
| inServiceDepth | output | 9 | Number of vectors in service |
| eoiError | output | 1 | Sticky misuse flag |

## Verification
The assertions rely on two facts. Every change to the in-service bits passes through the counted dispatch and retirement paths, so the depth always equals the number of set in-service bits. The inputs are also assumed to be two-state on every clock edge. The stimulus drives all strobes independently, with no protocol restriction. It regularly aims a request, a dispatch and a retirement at the same vector in one cycle, and it acknowledges notices at random, both while one is pending and while none is. A directed prologue sets up each corner case before the random phase: a word-0-only retirement, retirement at zero depth, and retirement with an unacknowledged notice.

// File: rtl/intr_eoi_pkg.sv
package intr_eoi_pkg;
  localparam int unsigned VEC_COUNT   = 256;
  localparam int unsigned GROUP_BITS  = 32;
  localparam int unsigned SKIP_GROUPS = 1;

  // Qualified strobes from control to the vector datapath
  typedef struct packed {
    logic takeAccept;
    logic moveService;
    logic retireTop;
  } ctrlStrobe_t;
endpackage

// File: rtl/isr_top_finder.sv
module isr_top_finder #(
  parameter int unsigned NUM_VEC  = 256,
  parameter int unsigned GRP_W    = 32,
  parameter int unsigned SKIP_GRP = 1,
  parameter int unsigned VEC_W    = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-SKIP_GRP*GRP_W-1:0] scanBits,
  output logic                              found,
  output logic [VEC_W-1:0]                  topVec
);
  localparam int unsigned SCAN_GRP = NUM_VEC / GRP_W - SKIP_GRP;
  localparam int unsigned BIT_W    = $clog2(GRP_W);

  logic [SCAN_GRP-1:0]       groupAny;
  logic [SCAN_GRP*BIT_W-1:0] groupTopFlat;

  // One priority encoder per word
  for (genvar g = 0; g < SCAN_GRP; g++) begin : gGroup
    logic [GRP_W-1:0] grpBits;
    logic [BIT_W-1:0] topBit;
    assign grpBits = scanBits[g*GRP_W +: GRP_W];
    assign groupAny[g] = |grpBits;
    always_comb begin
      topBit = '0;
      for (int b = 0; b < GRP_W; b++) begin
        if (grpBits[b]) topBit = BIT_W'(b);
      end
    end
    assign groupTopFlat[g*BIT_W +: BIT_W] = topBit;
  end

  // Word-level encoder: highest nonempty word wins
  always_comb begin
    found  = 1'b0;
    topVec = '0;
    for (int g = 0; g < SCAN_GRP; g++) begin
      if (groupAny[g]) begin
        found  = 1'b1;
        topVec = VEC_W'((g + SKIP_GRP) * GRP_W) + VEC_W'(groupTopFlat[g*BIT_W +: BIT_W]);
      end
    end
  end
endmodule

// File: rtl/intr_vec_datapath.sv
module intr_vec_datapath
  import intr_eoi_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 256,
  parameter int unsigned GRP_W    = 32,
  parameter int unsigned SKIP_GRP = 1,
  parameter int unsigned VEC_W    = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [VEC_W-1:0]   acceptVector,
  input  logic               acceptLevel,
  input  logic               acceptLocal,
  input  logic [VEC_W-1:0]   serviceVector,
  output logic [NUM_VEC-1:0] irrBits,
  output logic [NUM_VEC-1:0] isrBits,
  output logic [NUM_VEC-1:0] tmrBits,
  output logic               found,
  output logic [VEC_W-1:0]   topVec,
  output logic               topIsLevel,
  output logic               serviceBitSet
);
  localparam int unsigned LOW_W = SKIP_GRP * GRP_W;
  localparam logic [NUM_VEC-1:0] ONE = NUM_VEC'(1);

  logic [NUM_VEC-1:0] accMask, svcMask, retMask;

  assign accMask = strobe.takeAccept  ? (ONE << acceptVector)  : '0;
  assign svcMask = strobe.moveService ? (ONE << serviceVector) : '0;
  assign retMask = strobe.retireTop   ? (ONE << topVec)        : '0;

  isr_top_finder #(
    .NUM_VEC(NUM_VEC), .GRP_W(GRP_W), .SKIP_GRP(SKIP_GRP), .VEC_W(VEC_W)
  ) u_finder (
    .scanBits(isrBits[NUM_VEC-1:LOW_W]),
    .found   (found),
    .topVec  (topVec)
  );

  assign topIsLevel    = tmrBits[topVec];
  assign serviceBitSet = isrBits[serviceVector];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irrBits <= '0;
      isrBits <= '0;
      tmrBits <= '0;
    end else begin
      irrBits <= (irrBits & ~svcMask) | accMask;
      isrBits <= (isrBits & ~retMask) | svcMask;
      if (strobe.takeAccept) tmrBits[acceptVector] <= acceptLevel & ~acceptLocal;
    end
  end

  // R2: an accepted request is pending on the next cycle
  assert_accept_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeAccept |=> irrBits[$past(acceptVector)]);

  // R3: local sources are recorded edge-sensitive
  assert_local_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeAccept && acceptLocal) |=> !tmrBits[$past(acceptVector)]);

  // R5: the retired bit is gone unless re-dispatched in the same cycle
  assert_retire_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.retireTop && !(strobe.moveService && serviceVector == topVec))
      |=> !isrBits[$past(topVec)]);

  // R5: a retirement only happens when the finder saw a candidate
  assert_retire_has_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retireTop |-> found);
endmodule

// File: rtl/intr_eoi_ctrl.sv
module intr_eoi_ctrl
  import intr_eoi_pkg::*;
#(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned VEC_W   = $clog2(NUM_VEC),
  parameter int unsigned DEPTH_W = $clog2(NUM_VEC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               acceptValid,
  input  logic               serviceValid,
  input  logic [VEC_W-1:0]   serviceVector,
  input  logic               eoiValid,
  input  logic               msgAck,
  input  logic               found,
  input  logic [VEC_W-1:0]   topVec,
  input  logic               topIsLevel,
  input  logic               serviceBitSet,
  output ctrlStrobe_t        strobe,
  output logic [DEPTH_W-1:0] depth,
  output logic               errFlag,
  output logic               msgValid,
  output logic [VEC_W-1:0]   msgVector
);
  logic depthZero, msgBlocked, eoiAllowed, retire, svcCounts, errSet;

  assign depthZero  = (depth == '0);
  assign msgBlocked = msgValid && !msgAck;
  assign eoiAllowed = eoiValid && !depthZero && !msgBlocked;
  assign retire     = eoiAllowed && found;
  assign errSet     = eoiValid && (depthZero || msgBlocked);
  assign svcCounts  = serviceValid &&
                      (!serviceBitSet || (retire && topVec == serviceVector));

  assign strobe.takeAccept  = acceptValid;
  assign strobe.moveService = serviceValid;
  assign strobe.retireTop   = retire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth     <= '0;
      errFlag   <= 1'b0;
      msgValid  <= 1'b0;
      msgVector <= '0;
    end else begin
      depth <= depth + DEPTH_W'(svcCounts) - DEPTH_W'(retire);
      if (errSet) errFlag <= 1'b1;
      if (retire && topIsLevel) begin
        msgValid  <= 1'b1;
        msgVector <= topVec;
      end else if (msgAck) begin
        msgValid <= 1'b0;
      end
    end
  end

  // R9: error flag never clears outside reset
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R9: retirement at zero depth flags the error
  assert_zero_depth_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && depthZero) |=> errFlag);

  // R8: an unacknowledged notice holds its vector
  assert_msg_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgAck) |=> (msgValid && $stable(msgVector)));

  // R10: a refused retirement leaves the depth alone apart from dispatch
  assert_refused_eoi_R10: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && msgBlocked && !serviceValid) |=> (errFlag && $stable(depth)));
endmodule

// File: rtl/intr_accept_eoi.sv
module intr_accept_eoi
  import intr_eoi_pkg::*;
#(
  parameter int unsigned NUM_VEC  = VEC_COUNT,
  parameter int unsigned GRP_W    = GROUP_BITS,
  parameter int unsigned SKIP_GRP = SKIP_GROUPS,
  parameter int unsigned VEC_W    = $clog2(NUM_VEC),
  parameter int unsigned DEPTH_W  = $clog2(NUM_VEC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               acceptValid,
  input  logic [VEC_W-1:0]   acceptVector,
  input  logic               acceptLevel,
  input  logic               acceptLocal,
  input  logic               serviceValid,
  input  logic [VEC_W-1:0]   serviceVector,
  input  logic               eoiValid,
  output logic               eoiMsgValid,
  output logic [VEC_W-1:0]   eoiMsgVector,
  input  logic               eoiMsgAck,
  output logic [NUM_VEC-1:0] irrVec,
  output logic [NUM_VEC-1:0] isrVec,
  output logic [NUM_VEC-1:0] tmrVec,
  output logic [DEPTH_W-1:0] inServiceDepth,
  output logic               eoiError
);
  ctrlStrobe_t      strobe;
  logic             found, topIsLevel, serviceBitSet;
  logic [VEC_W-1:0] topVec;

  intr_vec_datapath #(
    .NUM_VEC(NUM_VEC), .GRP_W(GRP_W), .SKIP_GRP(SKIP_GRP), .VEC_W(VEC_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .acceptVector(acceptVector), .acceptLevel(acceptLevel), .acceptLocal(acceptLocal),
    .serviceVector(serviceVector),
    .irrBits(irrVec), .isrBits(isrVec), .tmrBits(tmrVec),
    .found(found), .topVec(topVec), .topIsLevel(topIsLevel),
    .serviceBitSet(serviceBitSet)
  );

  intr_eoi_ctrl #(
    .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .DEPTH_W(DEPTH_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .acceptValid(acceptValid), .serviceValid(serviceValid), .serviceVector(serviceVector),
    .eoiValid(eoiValid), .msgAck(eoiMsgAck),
    .found(found), .topVec(topVec), .topIsLevel(topIsLevel), .serviceBitSet(serviceBitSet),
    .strobe(strobe), .depth(inServiceDepth), .errFlag(eoiError),
    .msgValid(eoiMsgValid), .msgVector(eoiMsgVector)
  );

  // R4: the control counter and the datapath bits never disagree
  assert_depth_tracks_isr_R4: assert property (@(posedge clk) disable iff (!rstN)
    inServiceDepth == DEPTH_W'($countones(isrVec)));
endmodule

// File: tb/intr_accept_eoi_tb.sv
module intr_accept_eoi_tb;
  logic         clk = 1'b0;
  logic         rstN;
  logic         acceptValid, acceptLevel, acceptLocal, serviceValid, eoiValid, eoiMsgAck;
  logic [7:0]   acceptVector, serviceVector;
  logic         eoiMsgValid, eoiError;
  logic [7:0]   eoiMsgVector;
  logic [255:0] irrVec, isrVec, tmrVec;
  logic [8:0]   inServiceDepth;

  int checks = 0;
  int fails  = 0;

  logic [255:0] mIrr, mIsr, mTmr;
  int           mDepth;
  bit           mErr, mMsgV;
  logic [7:0]   mMsgVec;

  always #10 clk = ~clk;

  intr_accept_eoi u_dut (
    .clk(clk), .rstN(rstN),
    .acceptValid(acceptValid), .acceptVector(acceptVector),
    .acceptLevel(acceptLevel), .acceptLocal(acceptLocal),
    .serviceValid(serviceValid), .serviceVector(serviceVector),
    .eoiValid(eoiValid), .eoiMsgValid(eoiMsgValid), .eoiMsgVector(eoiMsgVector),
    .eoiMsgAck(eoiMsgAck), .irrVec(irrVec), .isrVec(isrVec), .tmrVec(tmrVec),
    .inServiceDepth(inServiceDepth), .eoiError(eoiError)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(irrVec == mIrr, "R2 pending bits", irrVec, mIrr);
    chk(tmrVec == mTmr, "R3 trigger bits", tmrVec, mTmr);
    chk(isrVec == mIsr, "R5 in-service bits", isrVec, mIsr);
    chk(inServiceDepth == 9'(mDepth), "R4 depth", 256'(inServiceDepth), 256'(mDepth));
    chk(eoiError == mErr, "R9 error flag", 256'(eoiError), 256'(mErr));
    chk(eoiMsgValid == mMsgV, "R7 notice valid", 256'(eoiMsgValid), 256'(mMsgV));
    if (mMsgV) chk(eoiMsgVector == mMsgVec, "R8 notice vector", 256'(eoiMsgVector), 256'(mMsgVec));
  endtask

  // One cycle: drive at negedge, advance the model, compare at next negedge
  task automatic drive(input bit a, input logic [7:0] av, input bit al, input bit alo,
                       input bit s, input logic [7:0] sv, input bit e, input bit k);
    logic [255:0] nIrr, nIsr, nTmr;
    int nDepth, top;
    bit nErr, nMsgV, ret;
    logic [7:0] nMsgVec;
    acceptValid = a; acceptVector = av; acceptLevel = al; acceptLocal = alo;
    serviceValid = s; serviceVector = sv; eoiValid = e; eoiMsgAck = k;
    nIrr = mIrr; nIsr = mIsr; nTmr = mTmr; nDepth = mDepth;
    nErr = mErr; nMsgV = mMsgV; nMsgVec = mMsgVec;
    ret = 0; top = -1;
    if (e) begin
      if (mDepth == 0 || (mMsgV && !k)) nErr = 1;
      else begin
        for (int v = 32; v < 256; v++) if (mIsr[v]) top = v;
        ret = (top >= 0);
      end
    end
    if (ret) begin nIsr[top] = 1'b0; nDepth--; end
    if (s) begin
      nIrr[sv] = 1'b0;
      if (!nIsr[sv]) begin nIsr[sv] = 1'b1; nDepth++; end
    end
    if (a) begin nIrr[av] = 1'b1; nTmr[av] = al && !alo; end
    if (ret && mTmr[top]) begin nMsgV = 1; nMsgVec = 8'(top); end
    else if (k) nMsgV = 0;
    @(posedge clk);
    mIrr = nIrr; mIsr = nIsr; mTmr = nTmr; mDepth = nDepth;
    mErr = nErr; mMsgV = nMsgV; mMsgVec = nMsgVec;
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    drive(0, 8'd0, 0, 0, 0, 8'd0, 0, 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    acceptValid = 0; acceptVector = 0; acceptLevel = 0; acceptLocal = 0;
    serviceValid = 0; serviceVector = 0; eoiValid = 0; eoiMsgAck = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mIrr = '0; mIsr = '0; mTmr = '0; mDepth = 0; mErr = 0; mMsgV = 0; mMsgVec = '0;
    chk(irrVec == '0 && isrVec == '0 && tmrVec == '0 && inServiceDepth == '0
        && !eoiMsgValid && !eoiError, "R1 reset state", isrVec | irrVec | tmrVec, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // Phase A: accept, dispatch, retire, notice handling
    doReset();
    drive(1, 8'd40, 1, 0, 0, 8'd0, 0, 0);
    chk(irrVec[40] && tmrVec[40], "R2 level request", {irrVec[40], tmrVec[40]}, 2'b11);
    drive(1, 8'd200, 0, 0, 0, 8'd0, 0, 0);
    chk(irrVec[200] && !tmrVec[200], "R2 edge request", {irrVec[200], tmrVec[200]}, 2'b10);
    drive(1, 8'd100, 1, 1, 0, 8'd0, 0, 0);
    chk(!tmrVec[100], "R3 local forced edge", 256'(tmrVec[100]), 256'(0));
    drive(0, 8'd0, 0, 0, 1, 8'd40, 0, 0);
    chk(!irrVec[40] && isrVec[40] && inServiceDepth == 1, "R4 dispatch", 256'(inServiceDepth), 256'(1));
    drive(0, 8'd0, 0, 0, 1, 8'd200, 0, 0);
    drive(0, 8'd0, 0, 0, 1, 8'd5, 0, 0);
    drive(0, 8'd0, 0, 0, 1, 8'd5, 0, 0);
    chk(inServiceDepth == 3, "R4 repeat dispatch not counted", 256'(inServiceDepth), 256'(3));
    drive(0, 8'd0, 0, 0, 0, 8'd0, 1, 0);
    chk(!isrVec[200] && isrVec[40] && !eoiMsgValid, "R7 edge retire no notice", 256'(eoiMsgValid), 256'(0));
    drive(0, 8'd0, 0, 0, 0, 8'd0, 1, 0);
    chk(eoiMsgValid && eoiMsgVector == 8'd40, "R7 level retire notice", 256'(eoiMsgVector), 256'(40));
    idle(); idle();
    chk(eoiMsgValid && eoiMsgVector == 8'd40, "R8 notice held", 256'(eoiMsgVector), 256'(40));
    drive(0, 8'd0, 0, 0, 0, 8'd0, 1, 0);
    chk(eoiError && isrVec[5] && inServiceDepth == 1, "R10 refused retirement", 256'(inServiceDepth), 256'(1));
    drive(0, 8'd0, 0, 0, 0, 8'd0, 0, 1);
    chk(!eoiMsgValid, "R8 acknowledge drops notice", 256'(eoiMsgValid), 256'(0));
    drive(1, 8'd77, 0, 0, 1, 8'd77, 0, 0);
    chk(irrVec[77] && isrVec[77], "R4 same-cycle request keeps pending", 256'(irrVec[77]), 256'(1));

    // Phase B: word 0 never retired
    doReset();
    drive(0, 8'd0, 0, 0, 1, 8'd5, 0, 0);
    drive(0, 8'd0, 0, 0, 0, 8'd0, 1, 0);
    chk(isrVec[5] && inServiceDepth == 1 && !eoiError, "R6 word zero untouched", isrVec, 256'(1) << 5);

    // Phase C: retirement at zero depth
    doReset();
    drive(0, 8'd0, 0, 0, 0, 8'd0, 1, 0);
    chk(eoiError && isrVec == '0 && inServiceDepth == 0, "R9 zero-depth error", 256'(eoiError), 256'(1));
    drive(1, 8'd60, 1, 0, 1, 8'd60, 0, 0);
    idle();
    chk(eoiError, "R9 error sticky", 256'(eoiError), 256'(1));

    // Phase D: constrained random mix
    doReset();
    for (int i = 0; i < 3000; i++) begin
      bit a, al, alo, s, e, k;
      logic [7:0] av, sv;
      a   = ($urandom_range(99) < 50);
      al  = $urandom_range(1);
      alo = ($urandom_range(99) < 25);
      av  = 8'($urandom_range(255));
      s   = ($urandom_range(99) < 40);
      sv  = ($urandom_range(3) == 0) ? av : 8'($urandom_range(255));
      e   = ($urandom_range(99) < 30);
      k   = $urandom_range(1);
      drive(a, av, al, alo, s, sv, e, k);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule